// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Timebase

This block keeps a 64-bit count of nanoseconds for time synchronisation. It adds a fixed nominal step of 16 ns on every clock cycle. A periodic corrector slews its rate: once every programmed number of cycles it adds or removes between 0 and 7 ns. Software works out the correction settings from a parts-per-billion figure and writes them as one 32-bit word. The block only applies them.

A small register port has a one-cycle write strobe and a combinational read. Through it, software can:
- pause the counter, load it in two 32-bit halves, and resume it;
- hold the corrector in reset while it changes the correction word;
- read the time coherently as a low word followed by a high word.

The register addresses are 0 control, 1 load-low, 2 load-high, 3 drift reset, 4 drift configuration, 5 time-low and 6 time-high. Address 7 and the load addresses read as zero.

Top module: `ns_timebase`

## Requirements
- R1: After reset the time is zero, the counter is running (address 0 reads 1), the drift reset bit (address 3) reads 0 and the drift configuration (address 4) reads 0.
- R2: While running with no correction due, the time grows by exactly 16 on every clock cycle.
- R3: Writing the value 2 to address 0 pauses the counter and writing 4 resumes it. Any other value written there has no effect. Bit 0 of address 0 reads 1 while running. While paused, the time holds its value.
- R4: While paused, a write to address 1 replaces time bits 31:0 and a write to address 2 replaces bits 63:32. While running, writes to either address are ignored.
- R5: Address 5 returns the live time bits 31:0. A read strobe on address 5 captures time bits 63:32 in the same cycle, and address 6 returns that captured value, so a low-then-high read forms one coherent 64-bit value.
- R6: The drift configuration word (address 4) has three fields: bits 27:0 give the interval count, bits 30:28 give the magnitude in ns, and bit 31 gives the direction (1 adds, 0 subtracts).
- R7: While running and out of drift reset with a nonzero magnitude, one cycle in every interval+1 running cycles steps by 16+magnitude (add) or 16-magnitude (subtract). The first such cycle is the (interval+1)-th running cycle after the drift reset is released.
- R8: A magnitude of zero, and so an all-zero configuration, disables correction whatever the interval.
- R9: Bit 0 of address 3 is the drift reset and reads back as written. While it is 1, no correction is applied and the interval count is held at zero.
- R10: A write to address 4 takes effect only while the drift reset bit is 1. At other times it is ignored and the configuration reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures the high word on a time-low read) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
Most internal faults in this block show up at the ports within one time read. A wrong step or a lost carry between halves changes the time read after a paused run by a fixed, predictable amount. An interval count that is off by one moves the number of corrections inside a known run length, so the final value is off by a multiple of the magnitude. A configuration that is not locked out, or a snapshot that is not taken, shows up on the very next readback of address 4 or address 6.

// File: rtl/ntb_pkg.sv
package ntb_pkg;

  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned INTERVAL_W = 28;
  localparam int unsigned MAG_W      = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_LOAD_LO = 3'd1,
    REG_LOAD_HI = 3'd2,
    REG_DRST    = 3'd3,
    REG_DCFG    = 3'd4,
    REG_TIME_LO = 3'd5,
    REG_TIME_HI = 3'd6
  } reg_addr_e;

  localparam logic [31:0] CMD_PAUSE  = 32'd2;
  localparam logic [31:0] CMD_RESUME = 32'd4;

  typedef struct packed {
    logic                  add;
    logic [MAG_W-1:0]      mag;
    logic [INTERVAL_W-1:0] interval;
  } drift_cfg_t;

endpackage

// File: rtl/ntb_regs.sv
module ntb_regs
  import ntb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [TIME_W-1:0]          time_now,
  output logic                       run,
  output logic                       drift_rst,
  output drift_cfg_t                 cfg,
  output logic [TIME_W/DATA_W-1:0]   load_half,
  output logic [DATA_W-1:0]          rdata
);

  localparam int unsigned NUM_HALF = TIME_W / DATA_W;

  logic       run_q, run_d;
  logic       drst_q, drst_d;
  drift_cfg_t cfg_q, cfg_d;
  logic [DATA_W-1:0] snap_q, snap_d;
  logic       snap_en;

  // next-state
  always_comb begin
    run_d  = run_q;
    drst_d = drst_q;
    cfg_d  = cfg_q;
    if (wr_en && addr == REG_CTRL) begin
      if (wdata == CMD_PAUSE)       run_d = 1'b0;
      else if (wdata == CMD_RESUME) run_d = 1'b1;
    end
    if (wr_en && addr == REG_DRST) drst_d = wdata[0];
    if (wr_en && addr == REG_DCFG && drst_q) cfg_d = drift_cfg_t'(wdata);
  end

  assign snap_en = rd_en && addr == REG_TIME_LO;
  assign snap_d  = time_now[TIME_W-1 -: DATA_W];

  // load strobes, only honoured while paused
  always_comb begin
    load_half = '0;
    if (wr_en && !run_q) begin
      if (addr == REG_LOAD_LO) load_half[0] = 1'b1;
      if (addr == REG_LOAD_HI) load_half[NUM_HALF-1] = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      drst_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      run_q  <= run_d;
      drst_q <= drst_d;
      cfg_q  <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTRL:    rdata[0] = run_q;
      REG_DRST:    rdata[0] = drst_q;
      REG_DCFG:    rdata    = DATA_W'(cfg_q);
      REG_TIME_LO: rdata    = time_now[DATA_W-1:0];
      REG_TIME_HI: rdata    = snap_q;
      default:     rdata    = '0;
    endcase
  end

  assign run       = run_q;
  assign drift_rst = drst_q;
  assign cfg       = cfg_q;

  // R10: configuration cannot move while the drift reset is released
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !drst_q |=> $stable(cfg_q));

  // R4: a load strobe never fires while running
  a_r4_load_only_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (load_half != '0) |-> !run_q);

  // R5: a time-low read captures the high half seen in that cycle
  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> snap_q == $past(time_now[TIME_W-1 -: DATA_W]));

endmodule

// File: rtl/ntb_drift.sv
module ntb_drift
  import ntb_pkg::*;
#(
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned NOMINAL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              drift_rst,
  input  drift_cfg_t        cfg,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] NOM = STEP_W'(NOMINAL);

  logic [INTERVAL_W-1:0] cnt_q, cnt_d;
  logic                  at_end;
  logic                  tick;
  logic [STEP_W-1:0]     mag_ext;

  assign at_end  = (cnt_q == cfg.interval);
  assign tick    = run && !drift_rst && (cfg.mag != '0) && at_end;
  assign mag_ext = STEP_W'(cfg.mag);

  always_comb begin
    cnt_d = cnt_q;
    if (drift_rst)   cnt_d = '0;
    else if (run)    cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    step = NOM;
    if (tick) step = cfg.add ? (NOM + mag_ext) : (NOM - mag_ext);
  end

  // R9: drift reset clears the interval count
  a_r9_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    drift_rst |=> cnt_q == '0);

  // R9: no correction while the drift reset is held
  a_r9_no_corr_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    drift_rst |-> step == NOM);

  // R8: zero magnitude means nominal stepping only
  a_r8_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mag == '0) |-> step == NOM);

  // R7: interval count never passes the programmed interval
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !drift_rst |-> cnt_q <= cfg.interval);

endmodule

// File: rtl/ntb_counter.sv
module ntb_counter #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [TIME_W/DATA_W-1:0] load_half,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [STEP_W-1:0]        step,
  output logic [TIME_W-1:0]        time_q
);

  localparam int unsigned NUM_HALF = TIME_W / DATA_W;

  logic [TIME_W-1:0] time_d;
  logic [TIME_W-1:0] sum;

  assign sum = time_q + TIME_W'(step);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    always_comb begin
      if (load_half[h])  time_d[h*DATA_W +: DATA_W] = wdata;
      else if (run)      time_d[h*DATA_W +: DATA_W] = sum[h*DATA_W +: DATA_W];
      else               time_d[h*DATA_W +: DATA_W] = time_q[h*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  // R3: paused with no load, time holds
  a_r3_hold_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && load_half == '0) |=> $stable(time_q));

  // R2: running, time moves by the step presented
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_half == '0) |=> time_q == $past(time_q) + TIME_W'($past(step)));

endmodule

// File: rtl/ns_timebase.sv
module ns_timebase
  import ntb_pkg::*;
#(
  parameter int unsigned TIME_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned NOMINAL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [63:0]       time_ns
);

  localparam int unsigned NUM_HALF = TIME_W / DATA_W;

  logic [1:0]            rst_sync;
  logic                  rst_int_n;
  logic                  run;
  logic                  drift_rst;
  drift_cfg_t            cfg;
  logic [NUM_HALF-1:0]   load_half;
  logic [STEP_W-1:0]     step;
  logic [TIME_W-1:0]     time_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ntb_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .time_now  (time_q),
    .run       (run),
    .drift_rst (drift_rst),
    .cfg       (cfg),
    .load_half (load_half),
    .rdata     (rdata)
  );

  ntb_drift #(.STEP_W(STEP_W), .NOMINAL(NOMINAL)) u_drift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .drift_rst (drift_rst),
    .cfg       (cfg),
    .step      (step)
  );

  ntb_counter #(.TIME_W(TIME_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .load_half (load_half),
    .wdata     (wdata),
    .step      (step),
    .time_q    (time_q)
  );

  assign time_ns = time_q;

  // R1: time is zero while in reset
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_int_n |=> (time_q == '0) || rst_int_n);

endmodule

// File: tb/tb_ns_timebase.sv
module tb_ns_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_ns;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ns_timebase dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .time_ns(time_ns)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo);
    rd(3'd6, hi);
    t = {hi, lo};
  endtask

  task automatic pause_load(input logic [63:0] v);
    wr(3'd0, 32'd2);
    wr(3'd1, v[31:0]);
    wr(3'd2, v[63:32]);
  endtask

  // resume, run n running cycles in total, pause
  task automatic run_for(input int n);
    wr(3'd0, 32'd4);
    if (n > 1) idle(n - 1);
    wr(3'd0, 32'd2);
  endtask

  task automatic program_drift(input logic [31:0] c);
    logic [31:0] d;
    wr(3'd3, 32'd1);
    rd(3'd3, d);
    check("R9 drift reset readback", {32'd0, d}, 64'd1);
    wr(3'd4, c);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 time zero in reset", time_ns, 64'd0);
    rst_n = 1'b1;
    idle(4);
    rd(3'd0, d); check("R1 running after reset", {32'd0, d}, 64'd1);
    rd(3'd3, d); check("R1 drift reset clear", {32'd0, d}, 64'd0);
    rd(3'd4, d); check("R1 config zero", {32'd0, d}, 64'd0);
  endtask

  task automatic t_load_read;
    logic [63:0] t;
    pause_load(64'h1234_5678_9ABC_DEF0);
    read_time(t);
    check("R4 load while paused", t, 64'h1234_5678_9ABC_DEF0);
    idle(5);
    read_time(t);
    check("R3 paused holds", t, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_nominal;
    logic [63:0] t;
    pause_load(64'd0);
    run_for(10);
    read_time(t);
    check("R2 nominal 16 per cycle", t, 64'd160);
  endtask

  task automatic t_ctrl_other;
    logic [31:0] d;
    logic [63:0] t;
    pause_load(64'd500);
    wr(3'd0, 32'd3);
    wr(3'd0, 32'd6);
    rd(3'd0, d); check("R3 other ctrl values ignored", {32'd0, d}, 64'd0);
    read_time(t); check("R3 still paused", t, 64'd500);
  endtask

  task automatic t_load_running;
    logic [63:0] t;
    pause_load(64'd1000);
    wr(3'd0, 32'd4);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd2, 32'h0000_00AA);
    wr(3'd0, 32'd2);
    read_time(t);
    check("R4 load ignored while running", t, 64'd1000 + 64'd48);
  endtask

  task automatic t_carry_snapshot;
    logic [31:0] lo, hi;
    logic [63:0] t;
    pause_load(64'h0000_0005_FFFF_FFF0);
    wr(3'd0, 32'd4);
    rd(3'd5, lo);
    rd(3'd6, hi);
    wr(3'd0, 32'd2);
    check("R5 coherent low/high read", {hi, lo}, 64'h0000_0005_FFFF_FFF0);
    read_time(t);
    check("R2 carry across halves", t, 64'h0000_0005_FFFF_FFF0 + 64'd48);
  endtask

  task automatic t_drift_add;
    logic [63:0] t;
    pause_load(64'd0);
    program_drift({1'b1, 3'd5, 28'd3});
    run_for(20);
    read_time(t);
    check("R7 add 5 every 4 cycles", t, 64'd320 + 64'd25);
  endtask

  task automatic t_drift_sub;
    logic [63:0] t;
    pause_load(64'd4000);
    program_drift({1'b0, 3'd7, 28'd0});
    run_for(8);
    read_time(t);
    check("R7 R6 subtract 7 every cycle", t, 64'd4000 + 64'd72);
  endtask

  task automatic t_zero_mag;
    logic [63:0] t;
    pause_load(64'd0);
    program_drift({1'b1, 3'd0, 28'd2});
    run_for(9);
    read_time(t);
    check("R8 zero magnitude no correction", t, 64'd144);
  endtask

  task automatic t_drift_held;
    logic [63:0] t;
    pause_load(64'd0);
    program_drift({1'b1, 3'd5, 28'd3});
    wr(3'd3, 32'd1);
    run_for(20);
    read_time(t);
    check("R9 no correction during drift reset", t, 64'd320);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_cfg_locked;
    logic [31:0] d;
    program_drift(32'hD000_0003);
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, d);
    check("R10 config write ignored outside drift reset", {32'd0, d}, 64'hD000_0003);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'h0000_0000);
    rd(3'd4, d);
    check("R10 config write accepted in drift reset", {32'd0, d}, 64'd0);
    wr(3'd3, 32'd0);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_load_read();
    t_nominal();
    t_ctrl_other();
    t_load_running();
    t_carry_snapshot();
    t_drift_add();
    t_drift_sub();
    t_zero_mag();
    t_drift_held();
    t_cfg_locked();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule